// File: doc/BRIEF.md
# Dual-Slot Register-Register Processor

This block is a straight-line processor core that takes in one 64-bit instruction bundle on every clock. A bundle carries two 32-bit register-to-register operations, one per slot. Both operations run in the same cycle on their own ALUs and commit on the same clock edge. The block holds its own bundle memory and a 32-entry by 32-bit register file. The register file has four read ports and two write ports, and entry zero always reads as zero.

There are no branches, no data memory and no immediates. The program counter simply advances by one bundle (8 bytes) per clock and wraps around the bundle memory. The block has two side ports so that a test environment or loader can set up state. One fills the bundle memory and the register file. The other reads back any register combinationally, which lets the architectural state be checked after each bundle.

Top module: `vliw_pair_core`

## Requirements
- R1: A synchronous reset sets the program counter to 0. No bundle commits any register write on a clock edge at which reset is high.
- R2: On each clock edge with reset low, the program counter increases by 8. The bundle executed at that edge is the memory word at index (pc / 8) modulo the memory depth.
- R3: Slot 0 is bundle bits [63:32] and slot 1 is bits [31:0]. Within a slot the fields are opcode [31:26], first source [25:21], second source [20:16], destination [15:11], an ignored shift field [10:6] and function [5:0].
- R4: With opcode 0, the function codes act as follows, with 32-bit wrap-around arithmetic: 0x20 and 0x21 give first plus second; 0x22 and 0x23 give first minus second; 0x24 gives bitwise AND; 0x25 gives bitwise OR.
- R5: Both slots read their sources from the register state before the bundle. A slot never sees the other slot's result from the same bundle.
- R6: When both slots write the same destination in one bundle, the slot 1 result is the value kept.
- R7: A slot whose opcode is nonzero, or whose function code is not one of those listed in R4, writes nothing.
- R8: Register 0 always reads as zero, and writes aimed at it are dropped.
- R9: A bundle's results can be read through the read-back port in the cycle right after the edge that executes it.
- R10: The loader port writes a register or a bundle word on the clock edge, including while reset is held. The read-back port returns the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_wr_en | input | 1 | Write enable for the bundle memory |
| imem_wr_idx | input | 5 | Bundle memory word index |
| imem_wr_word | input | 64 | Bundle to store |
| rf_load_en | input | 1 | Register preload enable |
| rf_load_idx | input | 5 | Register to preload |
| rf_load_val | input | 32 | Preload value |
| rf_peek_idx | input | 5 | Register to read back |
| rf_peek_val | output | 32 | Read-back value, combinational |
| pc_out | output | 32 | Current program counter |

## Verification
The bundle fetched at program counter p commits at the next rising edge. Its results and the counter value p+8 are visible from that edge until the following one. The bench therefore steps its reference model at each rising edge and reads back all 32 registers and the counter in the low half of the clock period that follows. Reset and preload results are read in the same way, one edge after the loader stimulus.

// File: rtl/vliw_pkg.sv
`timescale 1ns/1ps
package vliw_pkg;
  parameter int XLEN     = 32;
  parameter int NSLOT    = 2;
  parameter int NREG     = 32;
  parameter int RIDX     = $clog2(NREG);
  parameter int BUNDLE_W = NSLOT * XLEN;
  parameter int PC_STEP  = BUNDLE_W / 8;

  typedef logic [XLEN-1:0] word_t;
  typedef logic [RIDX-1:0] ridx_t;

  typedef struct packed {
    logic [5:0] opc;
    logic [4:0] src_a;
    logic [4:0] src_b;
    logic [4:0] dst;
    logic [4:0] shf;
    logic [5:0] fn;
  } rop_t;

  typedef enum logic [5:0] {
    FN_ADD  = 6'h20,
    FN_ADDU = 6'h21,
    FN_SUB  = 6'h22,
    FN_SUBU = 6'h23,
    FN_AND  = 6'h24,
    FN_OR   = 6'h25
  } fn_e;

  function automatic logic op_legal(input logic [5:0] opc, input logic [5:0] fn);
    logic ok;
    case (fn)
      FN_ADD, FN_ADDU, FN_SUB, FN_SUBU, FN_AND, FN_OR: ok = 1'b1;
      default: ok = 1'b0;
    endcase
    return ok && (opc == 6'd0);
  endfunction

  function automatic word_t alu_eval(input logic [5:0] fn, input word_t a, input word_t b);
    word_t r;
    case (fn)
      FN_ADD, FN_ADDU: r = a + b;
      FN_SUB, FN_SUBU: r = a - b;
      FN_AND:          r = a & b;
      FN_OR:           r = a | b;
      default:         r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/vliw_fetch.sv
`timescale 1ns/1ps
module vliw_fetch
  import vliw_pkg::*;
#(
  parameter int IMEM_WORDS = 32,
  localparam int IMEM_AW = $clog2(IMEM_WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IMEM_AW-1:0]  wr_idx,
  input  logic [BUNDLE_W-1:0] wr_word,
  output word_t               pc,
  output logic [BUNDLE_W-1:0] bundle
);
  localparam int LSB = $clog2(PC_STEP);

  logic [BUNDLE_W-1:0] mem [IMEM_WORDS];
  word_t pc_q;
  logic [IMEM_AW-1:0] fetch_idx;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_q + word_t'(PC_STEP);
  end

  assign fetch_idx = pc_q[LSB +: IMEM_AW];
  assign bundle    = mem[fetch_idx];
  assign pc        = pc_q;

  assert_pc_cleared_R1: assert property (@(posedge clk) rst |=> pc_q == '0)
    else $error("pc not cleared by reset");
  assert_pc_advance_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pc_q == $past(pc_q) + word_t'(PC_STEP))
    else $error("pc did not advance by one bundle");
endmodule

// File: rtl/vliw_slot_exec.sv
`timescale 1ns/1ps
module vliw_slot_exec
  import vliw_pkg::*;
(
  input  word_t  op_word,
  input  word_t  a_val,
  input  word_t  b_val,
  output ridx_t  a_idx,
  output ridx_t  b_idx,
  output logic   wr_en,
  output ridx_t  wr_idx,
  output word_t  wr_val
);
  rop_t op;
  logic legal;

  assign op     = rop_t'(op_word);
  assign legal  = op_legal(op.opc, op.fn);
  assign a_idx  = op.src_a;
  assign b_idx  = op.src_b;
  assign wr_idx = op.dst;
  assign wr_en  = legal && (op.dst != '0);
  assign wr_val = alu_eval(op.fn, a_val, b_val);
endmodule

// File: rtl/vliw_regfile.sv
`timescale 1ns/1ps
module vliw_regfile
  import vliw_pkg::*;
#(
  parameter int NWR = NSLOT,
  localparam int NRD = 2 * NWR
) (
  input  logic  clk,
  input  logic  rst,
  input  ridx_t rd_idx [NRD],
  output word_t rd_val [NRD],
  input  logic  wr_en  [NWR],
  input  ridx_t wr_idx [NWR],
  input  word_t wr_val [NWR],
  input  logic  ld_en,
  input  ridx_t ld_idx,
  input  word_t ld_val,
  input  ridx_t peek_idx,
  output word_t peek_val
);
  word_t regs [NREG];

  // later slots are written after earlier ones, so the highest slot wins
  always_ff @(posedge clk) begin
    if (ld_en && ld_idx != '0) regs[ld_idx] <= ld_val;
    for (int s = 0; s < NWR; s++) begin
      if (wr_en[s] && wr_idx[s] != '0) regs[wr_idx[s]] <= wr_val[s];
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_val[p] = (rd_idx[p] == '0) ? '0 : regs[rd_idx[p]];
  end
  assign peek_val = (peek_idx == '0) ? '0 : regs[peek_idx];

  for (genvar s = 0; s < NWR; s++) begin : g_chk
    assert_no_zero_write_R8: assert property (@(posedge clk) disable iff (rst)
      !(wr_en[s] && wr_idx[s] == '0))
      else $error("write enable raised for register 0");
    assert_no_write_in_reset_R1: assert property (@(posedge clk)
      rst |-> !wr_en[s])
      else $error("slot write during reset");
  end

  assert_last_slot_wins_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en[NWR-1] |=> regs[$past(wr_idx[NWR-1])] == $past(wr_val[NWR-1]))
    else $error("highest slot write was not kept");
endmodule

// File: rtl/vliw_pair_core.sv
`timescale 1ns/1ps
module vliw_pair_core
  import vliw_pkg::*;
#(
  parameter int IMEM_WORDS = 32,
  localparam int IMEM_AW = $clog2(IMEM_WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                imem_wr_en,
  input  logic [IMEM_AW-1:0]  imem_wr_idx,
  input  logic [63:0]         imem_wr_word,
  input  logic                rf_load_en,
  input  logic [4:0]          rf_load_idx,
  input  logic [31:0]         rf_load_val,
  input  logic [4:0]          rf_peek_idx,
  output logic [31:0]         rf_peek_val,
  output logic [31:0]         pc_out
);
  localparam int NRD = 2 * NSLOT;

  logic [BUNDLE_W-1:0] bundle;
  word_t slot_word [NSLOT];
  ridx_t rd_idx [NRD];
  word_t rd_val [NRD];
  logic  slot_we_raw [NSLOT];
  logic  slot_we [NSLOT];
  ridx_t slot_wa [NSLOT];
  word_t slot_wd [NSLOT];

  vliw_fetch #(.IMEM_WORDS(IMEM_WORDS)) u_fetch (
    .clk(clk), .rst(rst),
    .wr_en(imem_wr_en), .wr_idx(imem_wr_idx), .wr_word(imem_wr_word),
    .pc(pc_out), .bundle(bundle)
  );

  // slot 0 sits in the upper half of the bundle
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign slot_word[s] = bundle[BUNDLE_W-1-s*XLEN -: XLEN];

    vliw_slot_exec u_exec (
      .op_word(slot_word[s]),
      .a_val(rd_val[2*s]), .b_val(rd_val[2*s+1]),
      .a_idx(rd_idx[2*s]), .b_idx(rd_idx[2*s+1]),
      .wr_en(slot_we_raw[s]), .wr_idx(slot_wa[s]), .wr_val(slot_wd[s])
    );

    assign slot_we[s] = slot_we_raw[s] && !rst;

    assert_illegal_opcode_R7: assert property (@(posedge clk) disable iff (rst)
      (slot_word[s][31:26] != 6'd0) |-> !slot_we[s])
      else $error("nonzero opcode produced a write");
  end

  vliw_regfile #(.NWR(NSLOT)) u_rf (
    .clk(clk), .rst(rst),
    .rd_idx(rd_idx), .rd_val(rd_val),
    .wr_en(slot_we), .wr_idx(slot_wa), .wr_val(slot_wd),
    .ld_en(rf_load_en), .ld_idx(rf_load_idx), .ld_val(rf_load_val),
    .peek_idx(rf_peek_idx), .peek_val(rf_peek_val)
  );
endmodule

// File: tb/test_vliw_pair_core.sv
`timescale 1ns/1ps
module test_vliw_pair_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_wr_en = 1'b0;
  logic [4:0]  imem_wr_idx = '0;
  logic [63:0] imem_wr_word = '0;
  logic        rf_load_en = 1'b0;
  logic [4:0]  rf_load_idx = '0;
  logic [31:0] rf_load_val = '0;
  logic [4:0]  rf_peek_idx = '0;
  logic [31:0] rf_peek_val;
  logic [31:0] pc_out;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  logic [31:0] m_reg [32];
  logic [63:0] m_mem [32];
  logic [31:0] m_pc;
  int seed = 7;

  always #4 clk = ~clk;

  vliw_pair_core i_vliw_pair_core (
    .clk(clk), .rst(rst),
    .imem_wr_en(imem_wr_en), .imem_wr_idx(imem_wr_idx), .imem_wr_word(imem_wr_word),
    .rf_load_en(rf_load_en), .rf_load_idx(rf_load_idx), .rf_load_val(rf_load_val),
    .rf_peek_idx(rf_peek_idx), .rf_peek_val(rf_peek_val), .pc_out(pc_out)
  );

  function automatic logic [31:0] rop(input int fn, input int a, input int b, input int d);
    return {6'd0, a[4:0], b[4:0], d[4:0], 5'd0, fn[5:0]};
  endfunction

  // independent restatement of the operation table
  function automatic bit ref_exec(input logic [31:0] w, input logic [31:0] a,
                                  input logic [31:0] b, output logic [31:0] r);
    int fn = int'(w[5:0]);
    r = 32'd0;
    if (w[31:26] != 6'd0) return 0;
    if (fn == 32 || fn == 33) r = a + b;
    else if (fn == 34 || fn == 35) r = a + ~b + 32'd1;
    else if (fn == 36) r = a & b;
    else if (fn == 37) r = ~(~a | ~b) ^ (a ^ b) ^ (a & b) | (a | b);
    else return 0;
    return 1;
  endfunction

  function automatic string tag_of(input int idx);
    case (idx)
      0, 1: return "R5";
      2:    return "R6";
      3, 6: return "R4";
      4, 7: return "R7";
      5:    return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int r = 0; r < 32; r++) begin
      rf_peek_idx = 5'(r);
      #0.1;
      check(req, $sformatf("reg %0d", r), rf_peek_val, m_reg[r]);
    end
  endtask

  task automatic model_step();
    logic [31:0] nr [32];
    logic [63:0] w;
    logic [31:0] op, res;
    for (int r = 0; r < 32; r++) nr[r] = m_reg[r];
    w = m_mem[(m_pc >> 3) % 32];
    for (int s = 0; s < 2; s++) begin
      op = (s == 0) ? w[63:32] : w[31:0];
      if (ref_exec(op, m_reg[op[25:21]], m_reg[op[20:16]], res) && op[15:11] != 5'd0)
        nr[op[15:11]] = res;
    end
    for (int r = 0; r < 32; r++) m_reg[r] = nr[r];
    m_pc = m_pc + 32'd8;
  endtask

  function automatic logic [31:0] rand_op();
    int fns [8] = '{32, 33, 34, 35, 36, 37, 38, 0};
    logic [31:0] o;
    seed = seed * 1103515245 + 12345;
    o = rop(fns[(seed >>> 4) & 7], (seed >>> 8) & 31, (seed >>> 13) & 31, (seed >>> 18) & 31);
    if (((seed >>> 23) & 15) == 0) o[31:26] = 6'd3;
    return o;
  endfunction

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // program, R3 field layout: {opc, rs, rt, rd, shamt, funct}
    m_mem[0] = {rop(32, 9, 10, 8), rop(32, 8, 9, 7)};
    m_mem[1] = {rop(37, 2, 0, 1),  rop(37, 1, 0, 2)};
    m_mem[2] = {rop(32, 4, 5, 3),  rop(35, 4, 5, 3)};
    m_mem[3] = {rop(36, 20, 21, 11), rop(37, 12, 21, 12)};
    m_mem[4] = {rop(32, 1, 2, 13) | 32'h0400_0000, rop(38, 1, 2, 14)};
    m_mem[5] = {rop(32, 20, 20, 0), rop(34, 1, 2, 0)};
    m_mem[6] = {rop(33, 20, 20, 15), rop(34, 0, 20, 16)};
    m_mem[7] = 64'd0;
    for (int i = 8; i < 32; i++) m_mem[i] = {rand_op(), rand_op()};

    for (int r = 0; r < 32; r++) m_reg[r] = (r == 0) ? 32'd0 : 32'(r);
    m_reg[20] = 32'hFFFF_FFFF;
    m_reg[21] = 32'h0F0F_00FF;
    m_reg[12] = 32'hA000_0003;
    m_pc = 32'd0;

    // R10: preload through the loader port while reset is held
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      imem_wr_en = 1'b1; imem_wr_idx = 5'(i); imem_wr_word = m_mem[i];
      rf_load_en = 1'b1; rf_load_idx = 5'(i);
      rf_load_val = (i == 0) ? 32'hDEAD_BEEF : m_reg[i];
      @(negedge clk);
    end
    imem_wr_en = 1'b0; rf_load_en = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset holds pc at zero and no bundle commits; R8/R10 preload of r0 dropped
    check("R1", "pc in reset", pc_out, 32'd0);
    check_regs("R10");

    rst = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      // R9: results visible one edge after the bundle is fetched
      check("R2", "pc", pc_out, m_pc);
      check_regs(c < 8 ? tag_of(c) : "R4");
      if (c == 0) begin
        rf_peek_idx = 5'd8; #0.1; check("R5", "r8 explicit", rf_peek_val, 32'd19);
        rf_peek_idx = 5'd7; #0.1; check("R5", "r7 explicit", rf_peek_val, 32'd17);
      end
      if (c == 2) begin
        rf_peek_idx = 5'd3; #0.1; check("R6", "r3 explicit", rf_peek_val, 32'hFFFF_FFFF);
      end
    end

    // R1: reset mid-run clears pc
    rst = 1'b1;
    @(negedge clk);
    check("R1", "pc after reset", pc_out, 32'd0);
    @(negedge clk);
    m_pc = 32'd0;
    check_regs("R1");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule